// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes an unpacked floating-point value and turns it into a 32-bit IEEE-754 single-precision word. The value arrives as a class tag, a sign, a signed unbiased exponent, a significand, and a sticky bit. The significand carries an explicit leading one, the fraction bits, and two extra low-order bits (guard and round). A 2-bit mode selects the rounding direction.

The block does four jobs:
- It rounds the significand to 23 fraction bits.
- It denormalises values below the normal range.
- It promotes a subnormal that rounds up into the smallest normal.
- It resolves exponent overflow to either infinity or the largest finite value, depending on the mode and the sign.

Three flags come out next to the word: inexact, overflow (also acting as operand error), and underflow. All results are registered and appear one cycle after an input strobe. A typical use is the final write-back stage of an arithmetic unit whose datapath keeps values in a wider unpacked form.

Top module: `fsp_pack`

## Requirements
- R1: The word and flags are registered. `valid_o` is high exactly in the cycle after `valid_i` was high. When `valid_i` is low, the outputs hold their previous values. All outputs are zero after reset.
- R2: Class encoding for `cls_i` is 0 = zero, 1 = number, 2 = infinity, 3 = NaN. A zero packs to the sign bit alone. An infinity packs to the sign, exponent field 0xFF and fraction 0. Neither sets any flag.
- R3: A NaN packs to the sign, exponent field 0xFF, and fraction `sig_i[24:2]` with bit 22 of the word forced to 1. No flags are set.
- R4: Rounding mode encoding for `rmode_i` is 0 = nearest with ties to even, 1 = toward zero, 2 = toward minus infinity, 3 = toward plus infinity. Inexact is set whenever any discarded bit or `sticky_i` is nonzero.
- R5: For a number, the biased exponent is `exp_i` + 127. When that value is 1 or more, the word holds the biased exponent and the rounded `sig_i[24:2]` as the fraction. `sig_i[25]` is the leading one.
- R6: When a normal significand rounds up to 2.0, the exponent field goes up by one and the fraction field is 0.
- R7: When the biased exponent is 0 or less, the significand is shifted right by (1 − biased) places before rounding. Bits shifted out join the sticky bit. The exponent field is 0.
- R8: A subnormal that rounds up to the implicit-one position packs to exponent field 1 with fraction 0, and underflow is not set.
- R9: When the final biased exponent is 255 or more, both overflow and inexact are set. The word is infinity in mode 0. It is also infinity in mode 3 for a positive sign and in mode 2 for a negative sign. In every other case it is the signed largest finite value: exponent 0xFE with an all-ones fraction.
- R10: Underflow is set when a number packs with exponent field 0 and the result is inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| cls_i | input | 2 | Class tag |
| sign_i | input | 1 | Sign |
| exp_i | input | 10 | Unbiased exponent, two's complement |
| sig_i | input | 26 | Leading one, 23 fraction bits, guard, round |
| sticky_i | input | 1 | OR of all bits below round |
| rmode_i | input | 2 | Rounding mode |
| valid_o | output | 1 | Result strobe |
| word_o | output | 32 | Packed single-precision word |
| inexact_o | output | 1 | Result was rounded |
| ovf_o | output | 1 | Overflow / operand error |
| unf_o | output | 1 | Inexact subnormal result |

## Verification
The checker assumes that every number-class input arrives already normalised, with `sig_i[25]` set. It also assumes that `exp_i` stays inside its two's-complement range. Under those conditions the overflow properties compare only the final exponent with the mode. The stimulus uses this conditioning for every number-class vector: it ORs the leading one into each significand pattern. It also sweeps exponents that cross the subnormal floor, the promote boundary, and the top of the normal range, across every mode, sign, and sticky value.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_DOWN = 2'd2,
    RM_UP   = 2'd3
  } rmode_e;
endpackage

// File: rtl/fsp_rshift_sticky.sv
module fsp_rshift_sticky #(
  parameter int W    = 26,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    in_i,
  input  logic [SH_W-1:0] amt_i,
  output logic [W-1:0]    out_o,
  output logic            lost_o
);
  logic [W-1:0] mask;

  assign out_o  = in_i >> amt_i;
  assign mask   = ~({W{1'b1}} << amt_i);
  assign lost_o = |(in_i & mask);
endmodule

// File: rtl/fsp_round_dec.sv
module fsp_round_dec
  import fsp_pkg::*;
(
  input  logic [1:0] rmode_i,
  input  logic       sign_i,
  input  logic       lsb_i,
  input  logic       g_i,
  input  logic       r_i,
  input  logic       s_i,
  output logic       inc_o,
  output logic       inexact_o
);
  rmode_e mode;

  assign mode      = rmode_e'(rmode_i);
  assign inexact_o = g_i | r_i | s_i;

  always_comb begin
    unique case (mode)
      RM_NEAR: inc_o = g_i & (r_i | s_i | lsb_i);
      RM_ZERO: inc_o = 1'b0;
      RM_DOWN: inc_o = sign_i & inexact_o;
      RM_UP:   inc_o = ~sign_i & inexact_o;
      default: inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fsp_ovf_sel.sv
module fsp_ovf_sel
  import fsp_pkg::*;
(
  input  logic [1:0] rmode_i,
  input  logic       sign_i,
  output logic       to_inf_o
);
  always_comb begin
    unique case (rmode_e'(rmode_i))
      RM_NEAR: to_inf_o = 1'b1;
      RM_ZERO: to_inf_o = 1'b0;
      RM_DOWN: to_inf_o = sign_i;
      RM_UP:   to_inf_o = ~sign_i;
      default: to_inf_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fsp_pack.sv
module fsp_pack
  import fsp_pkg::*;
#(
  parameter int FRAC_W = 23,
  parameter int EXPF_W = 8,
  parameter int EXPI_W = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [1:0]                 cls_i,
  input  logic                       sign_i,
  input  logic [EXPI_W-1:0]          exp_i,
  input  logic [FRAC_W+2:0]          sig_i,
  input  logic                       sticky_i,
  input  logic [1:0]                 rmode_i,
  output logic                       valid_o,
  output logic [FRAC_W+EXPF_W:0]     word_o,
  output logic                       inexact_o,
  output logic                       ovf_o,
  output logic                       unf_o
);
  localparam int SIG_W  = FRAC_W + 3;
  localparam int WORD_W = FRAC_W + EXPF_W + 1;
  localparam int BIAS   = (1 << (EXPF_W - 1)) - 1;
  localparam int EMAX   = (1 << EXPF_W) - 1;
  localparam int BE_W   = EXPI_W + 2;
  localparam int SH_MAX = SIG_W + 1;
  localparam int SH_W   = $clog2(SH_MAX + 1);

  // exponent biasing and subnormal shift amount
  logic signed [BE_W-1:0] biased, exp_fin;
  logic [BE_W-1:0]        neg_u;
  logic                   is_sub;
  logic [SH_W-1:0]        amt;

  assign biased = $signed({{(BE_W-EXPI_W){exp_i[EXPI_W-1]}}, exp_i}) + $signed(BE_W'(BIAS));
  assign is_sub = biased[BE_W-1] || (biased == '0);
  assign neg_u  = BE_W'(1) - $unsigned(biased);
  assign amt    = !is_sub ? '0 :
                  (neg_u > BE_W'(SH_MAX)) ? SH_W'(SH_MAX) : neg_u[SH_W-1:0];

  logic [SIG_W-1:0] sh;
  logic             lost;

  fsp_rshift_sticky #(.W(SIG_W), .SH_W(SH_W)) u_shift (
    .in_i   (sig_i),
    .amt_i  (amt),
    .out_o  (sh),
    .lost_o (lost)
  );

  logic inc, inx;

  fsp_round_dec u_round (
    .rmode_i   (rmode_i),
    .sign_i    (sign_i),
    .lsb_i     (sh[2]),
    .g_i       (sh[1]),
    .r_i       (sh[0]),
    .s_i       (sticky_i | lost),
    .inc_o     (inc),
    .inexact_o (inx)
  );

  logic to_inf;

  fsp_ovf_sel u_ovf (
    .rmode_i  (rmode_i),
    .sign_i   (sign_i),
    .to_inf_o (to_inf)
  );

  // rounded significand: one bit wider to catch the carry into 2.0
  logic [FRAC_W+1:0] rounded;
  logic              carry, promote, ovf;

  assign rounded = {1'b0, sh[SIG_W-1:2]} + {{(FRAC_W+1){1'b0}}, inc};
  assign carry   = rounded[FRAC_W+1];
  assign promote = rounded[FRAC_W];
  assign exp_fin = biased + $signed({{(BE_W-1){1'b0}}, carry});
  assign ovf     = !is_sub && (exp_fin >= $signed(BE_W'(EMAX)));

  logic [WORD_W-1:0] word_d;
  logic              inx_d, ovf_d, unf_d;

  always_comb begin
    word_d = '0;
    inx_d  = 1'b0;
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    unique case (cls_e'(cls_i))
      CLS_ZERO: word_d = {sign_i, {(WORD_W-1){1'b0}}};
      CLS_INF:  word_d = {sign_i, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_NAN:  word_d = {sign_i, {EXPF_W{1'b1}}, 1'b1, sig_i[SIG_W-3:2]};
      CLS_NUM: begin
        inx_d = inx;
        if (is_sub) begin
          // promote lands on exponent 1 with a zero fraction
          word_d = {sign_i, {(EXPF_W-1){1'b0}}, promote, rounded[FRAC_W-1:0]};
          unf_d  = inx & ~promote;
        end else if (ovf) begin
          ovf_d = 1'b1;
          inx_d = 1'b1;
          word_d = to_inf ? {sign_i, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}}
                          : {sign_i, {(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else begin
          word_d = {sign_i, exp_fin[EXPF_W-1:0], rounded[FRAC_W-1:0]};
        end
      end
      default: word_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      word_o    <= '0;
      inexact_o <= 1'b0;
      ovf_o     <= 1'b0;
      unf_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        word_o    <= word_d;
        inexact_o <= inx_d;
        ovf_o     <= ovf_d;
        unf_o     <= unf_d;
      end
    end
  end
endmodule

// File: rtl/fsp_pack_chk.sv
module fsp_pack_chk #(
  parameter int FRAC_W = 23,
  parameter int EXPF_W = 8,
  parameter int EXPI_W = 10
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [1:0]             cls_i,
  input logic                   sign_i,
  input logic [EXPI_W-1:0]      exp_i,
  input logic [FRAC_W+2:0]      sig_i,
  input logic                   sticky_i,
  input logic [1:0]             rmode_i,
  input logic                   valid_o,
  input logic [FRAC_W+EXPF_W:0] word_o,
  input logic                   inexact_o,
  input logic                   ovf_o,
  input logic                   unf_o
);
  localparam int WORD_W = FRAC_W + EXPF_W + 1;
  localparam logic [EXPF_W-1:0] EALL = '1;
  localparam logic [EXPF_W-1:0] EBIG = EALL - 1'b1;

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(word_o) && $stable(ovf_o) && $stable(unf_o)));
  // R2
  zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == 2'd0) |=>
      (word_o[WORD_W-1] == $past(sign_i) && word_o[WORD_W-2:0] == '0 && !inexact_o));
  // R3
  nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == 2'd3) |=>
      (word_o[WORD_W-2:FRAC_W] == EALL && word_o[FRAC_W-1] && !ovf_o));
  // R9
  ovf_inx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> inexact_o);
  // R9
  rz_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == 2'd1 && rmode_i == 2'd1) |=>
      (!ovf_o || word_o[WORD_W-2:FRAC_W] == EBIG));
  // R10
  unf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (inexact_o && word_o[WORD_W-2:FRAC_W] == '0));
endmodule

bind fsp_pack fsp_pack_chk #(.FRAC_W(FRAC_W), .EXPF_W(EXPF_W), .EXPI_W(EXPI_W)) u_chk (.*);

// File: tb/tb_fsp_pack.sv
`timescale 1ns/1ps
module tb_fsp_pack;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  cls_i = '0;
  logic        sign_i = 1'b0;
  logic [9:0]  exp_i = '0;
  logic [25:0] sig_i = '0;
  logic        sticky_i = 1'b0;
  logic [1:0]  rmode_i = '0;
  logic        valid_o;
  logic [31:0] word_o;
  logic        inexact_o, ovf_o, unf_o;

  int vectors = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  fsp_pack dut (.*);

  // packed {unf, ovf, inexact, word}
  function automatic logic [34:0] ref_pack(input int cls, input bit sg, input int e,
                                           input longint s, input bit st, input int rm);
    longint q, rem, half;
    int b, d;
    bit nz, gt, tie, inc, toinf;
    logic [31:0] w;
    bit unf, ovf;
    unf = 0; ovf = 0;
    if (cls == 0) return {3'b000, sg, 31'd0};
    if (cls == 2) return {3'b000, sg, 8'hFF, 23'd0};
    if (cls == 3) return {3'b000, sg, 8'hFF, 23'((s >> 2) | 64'h400000)};
    b = e + 127;
    d = (b <= 0) ? 3 - b : 2;
    if (d > 40) d = 40;
    q    = s >> d;
    rem  = s & ((64'd1 << d) - 1);
    half = 64'd1 << (d - 1);
    nz   = (rem != 0) || st;
    gt   = (rem > half) || (rem == half && st);
    tie  = (rem == half) && !st;
    case (rm)
      0: inc = gt || (tie && q[0]);
      1: inc = 0;
      2: inc = sg && nz;
      default: inc = !sg && nz;
    endcase
    q = q + longint'(inc);
    if (b <= 0) begin
      if (q == (64'd1 << 23)) w = {sg, 8'd1, 23'd0};
      else begin
        w = {sg, 8'd0, 23'(q)};
        unf = nz;
      end
    end else begin
      if (q == (64'd1 << 24)) begin
        b = b + 1;
        q = 0;
      end
      if (b >= 255) begin
        ovf = 1; nz = 1;
        toinf = (rm == 0) || (rm == 3 && !sg) || (rm == 2 && sg);
        w = toinf ? {sg, 8'hFF, 23'd0} : {sg, 8'hFE, 23'h7FFFFF};
      end else w = {sg, 8'(b), 23'(q)};
    end
    return {unf, ovf, nz, w};
  endfunction

  function automatic string tag_of(input int cls, input int e, input logic [34:0] ex);
    if (cls == 0 || cls == 2) return "R2";
    if (cls == 3) return "R3";
    if (ex[33]) return "R9";
    if (e + 127 <= 0) begin
      if (ex[30:23] == 8'd1) return "R8";
      return ex[34] ? "R10 R7" : "R7 R4";
    end
    if (ex[30:23] != 8'(e + 127)) return "R6";
    return "R5 R4";
  endfunction

  function automatic logic [25:0] pat(input int k);
    case (k)
      0: return 26'h2000000;
      1: return 26'h2000001;
      2: return 26'h2000002;
      3: return 26'h2000003;
      4: return 26'h2000006;
      5: return 26'h3FFFFFF;
      6: return 26'h3FFFFFC;
      7: return 26'h3FFFFFD;
      8: return 26'h2AAAAAA;
      9: return 26'h3555555;
      10: return 26'h2000004;
      11: return 26'h3FFFFFE;
      default: return 26'h2000000 | 26'((32'(k) * 32'h9E3779B1) >> 7);
    endcase
  endfunction

  task automatic apply(input int cls, input bit sg, input int e, input logic [25:0] s,
                       input bit st, input int rm);
    logic [34:0] ex, got;
    @(negedge clk_i);
    cls_i = 2'(cls); sign_i = sg; exp_i = 10'(e); sig_i = s;
    sticky_i = st; rmode_i = 2'(rm); valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    ex  = ref_pack(cls, sg, e, longint'(s), st, rm);
    got = {unf_o, ovf_o, inexact_o, word_o};
    vectors++;
    if (got !== ex || valid_o !== 1'b1) begin
      fails++;
      $display("FAIL %s cls=%0d e=%0d sig=%h st=%0d rm=%0d sg=%0d got=%h/v%0d exp=%h",
               tag_of(cls, e, ex), cls, e, s, st, rm, sg, got, valid_o, ex);
    end
  endtask

  task automatic sweep_exp(input int e);
    for (int rm = 0; rm < 4; rm++)
      for (int sg = 0; sg < 2; sg++)
        for (int k = 0; k < 16; k++)
          for (int st = 0; st < 2; st++)
            apply(1, sg[0], e, pat(k), st[0], rm);
  endtask

  initial begin : wdog
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    repeat (3) @(negedge clk_i);
    vectors++;
    // R1 reset state
    if (valid_o !== 1'b0 || word_o !== 32'd0 || {inexact_o, ovf_o, unf_o} !== 3'b000) begin
      fails++;
      $display("FAIL R1 reset got=%h/%b exp=0", word_o, {valid_o, inexact_o, ovf_o, unf_o});
    end
    rst_ni = 1'b1;

    // R2, R3 special classes
    for (int cls = 0; cls < 4; cls += 1)
      if (cls != 1)
        for (int sg = 0; sg < 2; sg++)
          for (int k = 0; k < 16; k++)
            apply(cls, sg[0], k * 7 - 50, pat(k) ^ 26'(k * 3), k[0], k % 4);

    // R1 hold: valid low leaves result untouched
    held = word_o;
    repeat (3) @(negedge clk_i);
    vectors++;
    if (valid_o !== 1'b0 || word_o !== held) begin
      fails++;
      $display("FAIL R1 hold got=%h/v%0d exp=%h/v0", word_o, valid_o, held);
    end

    // R4..R10 across subnormal floor, normal range top and extremes
    for (int e = -165; e <= -115; e++) sweep_exp(e);
    for (int e = 120; e <= 130; e++) sweep_exp(e);
    sweep_exp(-500);
    sweep_exp(500);
    sweep_exp(-1);
    sweep_exp(0);
    sweep_exp(1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule